// File: doc/BRIEF.md
# Configurable Multiplexer Logic Cell

This block is a single fine-grained logic cell, as found in the array of a programmable device. Its combinational core is a 4-to-1 multiplexer over four data inputs. Each of its two select lines is formed by a small gate. The low select is the AND of two inputs and the high select is the OR of two inputs. The cell therefore realises an 8-input function on `y_o`, which stays valid whatever the storage configuration is.

A static 2-bit mode field places a storage element behind the multiplexer. The mode can skip the element altogether or choose one of three elements:
- an edge-triggered flip-flop with asynchronous clear;
- a plain transparent latch;
- a transparent latch with clear.

In the clearable-latch mode the latch is fed from a narrower 2-to-1 front end instead of the full function. The result of the selected path appears on `q_o`. The mode is set once and is changed only while the clear is held.

Top module: `mux_logic_cell`

## Requirements
- R1: The low select is `a_i[0] & b_i[0]` and the high select is `a_i[1] | b_i[1]`.
- R2: `y_o` equals `d_i[{s1,s0}]`, so `d_i[0]`, `d_i[1]`, `d_i[2]` and `d_i[3]` are picked by select values 00, 01, 10 and 11. This holds in every mode.
- R3: With `mode_i` = 00, `q_o` follows `y_o` combinationally. The clock and the clear have no effect on it.
- R4: With `mode_i` = 01, `q_o` takes the value of `y_o` on each rising edge of `clk_i`.
- R5: With `mode_i` = 01, `q_o` holds between rising edges, whatever the data inputs or the falling edges of `clk_i` do.
- R6: With `mode_i` = 10 or 11, the latch is transparent while `clk_i` is high.
- R7: With `mode_i` = 10 or 11, `q_o` holds while `clk_i` is low, whatever the data inputs do.
- R8: With `mode_i` = 10, `clr_ni` has no effect on `q_o`.
- R9: With `mode_i` = 11, the latch input is `d_i[1]` when `a_i[0] & b_i[0]` is 1 and `d_i[0]` otherwise. `d_i[3:2]`, `a_i[1]` and `b_i[1]` do not reach `q_o`.
- R10: With `mode_i` = 01 or 11, a low `clr_ni` forces `q_o` to 0 at once, whatever the level or edges of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Flip-flop clock in mode 01, latch gate in modes 10 and 11 |
| clr_ni | input | 1 | Asynchronous active-low clear of the storage element |
| mode_i | input | 2 | Static configuration: 00 bypass, 01 flip-flop, 10 latch, 11 latch with clear |
| d_i | input | 4 | Multiplexer data inputs, indexed by {high select, low select} |
| a_i | input | 2 | First operand of each select gate (bit 0 feeds AND, bit 1 feeds OR) |
| b_i | input | 2 | Second operand of each select gate (bit 0 feeds AND, bit 1 feeds OR) |
| y_o | output | 1 | Combinational multiplexer result |
| q_o | output | 1 | Registered, latched or bypassed result |

## Verification
A wrong select gate or a swapped data index shows on `y_o` in the same delta. An exhaustive sweep of all 256 input combinations in every mode exposes it. A storage fault is a wrong value held on `q_o`. In flip-flop mode it appears one rising edge late, or never if the capture edge is missed. In latch modes it appears while the gate is low, when a transparent path would let data changes through.

A clear that is wrongly gated by mode shows immediately in the plain latch mode, where the latch must keep a 1 under a low clear. A reduced front end that is wired to the full function shows when the high data inputs differ from the low ones.

// File: rtl/cell_pkg.sv
package cell_pkg;
  typedef enum logic [1:0] {
    MODE_COMB = 2'b00,
    MODE_DFF  = 2'b01,
    MODE_LAT  = 2'b10,
    MODE_LATC = 2'b11
  } cell_mode_e;

  localparam int unsigned SEL_W  = 2;
  localparam int unsigned DATA_N = 1 << SEL_W;
endpackage

// File: rtl/cell_select.sv
module cell_select (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [1:0] sel_o
);
  assign sel_o[0] = a_i[0] & b_i[0];
  assign sel_o[1] = a_i[1] | b_i[1];
endmodule

// File: rtl/cell_mux.sv
module cell_mux #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N    = 1 << SEL_W
) (
  input  logic [N-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);
  assign y_o = d_i[sel_i];
endmodule

// File: rtl/cell_store.sv
module cell_store
  import cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       clr_ni,
  input  cell_mode_e mode_i,
  input  logic       d_i,
  output logic       q_o
);
  logic q_ff, q_lat, lat_clr;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) q_ff <= 1'b0;
    else         q_ff <= d_i;
  end

  // clear reaches the latch only in the clearable-latch mode
  assign lat_clr = !clr_ni && (mode_i == MODE_LATC);

  always_latch begin
    if (lat_clr)    q_lat = 1'b0;
    else if (clk_i) q_lat = d_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_COMB: q_o = d_i;
      MODE_DFF:  q_o = q_ff;
      default:   q_o = q_lat;
    endcase
  end
endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell
  import cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       clr_ni,
  input  logic [1:0] mode_i,
  input  logic [3:0] d_i,
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic       y_o,
  output logic       q_o
);
  cell_mode_e mode;
  logic [SEL_W-1:0] sel;
  logic y_full, y_red, d_store;

  assign mode = cell_mode_e'(mode_i);

  cell_select u_sel (.a_i(a_i), .b_i(b_i), .sel_o(sel));

  cell_mux #(.SEL_W(SEL_W)) u_mux_full (
    .d_i(d_i), .sel_i(sel), .y_o(y_full)
  );

  // narrow front end: two data inputs, AND select term only
  cell_mux #(.SEL_W(1)) u_mux_red (
    .d_i(d_i[1:0]), .sel_i(sel[0]), .y_o(y_red)
  );

  assign d_store = (mode == MODE_LATC) ? y_red : y_full;

  cell_store u_store (
    .clk_i(clk_i), .clr_ni(clr_ni), .mode_i(mode), .d_i(d_store), .q_o(q_o)
  );

  assign y_o = y_full;
endmodule

// File: rtl/mux_logic_cell_chk.sv
module mux_logic_cell_chk (
  input logic       clk_i,
  input logic       clr_ni,
  input logic [1:0] mode_i,
  input logic [3:0] d_i,
  input logic [1:0] a_i,
  input logic [1:0] b_i,
  input logic       y_o,
  input logic       q_o
);
  // R4
  a_r4_flop_capture: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (mode_i == 2'b01) |=> (mode_i != 2'b01 || q_o == $past(y_o)));

  // R10
  a_r10_clear_forces_zero: assert property (@(posedge clk_i)
    (!clr_ni && (mode_i == 2'b01 || mode_i == 2'b11)) |-> (q_o == 1'b0));

  // R3
  a_r3_bypass: assert property (@(posedge clk_i)
    (mode_i == 2'b00) |-> (q_o == y_o));

  // R6
  a_r6_latch_transparent: assert property (@(negedge clk_i)
    (mode_i == 2'b10) |-> (q_o == y_o));

  // R9
  a_r9_reduced_latch: assert property (@(negedge clk_i) disable iff (!clr_ni)
    (mode_i == 2'b11) |-> (q_o == ((a_i[0] & b_i[0]) ? d_i[1] : d_i[0])));
endmodule

bind mux_logic_cell mux_logic_cell_chk u_chk (.*);

// File: tb/mux_logic_cell_test.sv
module mux_logic_cell_test;
  logic clk = 1'b0;
  logic cell_clk = 1'b0;
  logic clr_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [3:0] d = 4'h0;
  logic [1:0] a = 2'b00, b = 2'b00;
  logic y, q;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_logic_cell uut (
    .clk_i(cell_clk), .clr_ni(clr_n), .mode_i(mode),
    .d_i(d), .a_i(a), .b_i(b), .y_o(y), .q_o(q)
  );

  // step: mode[16:15] clk[14] clr[13] d[12:9] a[8:7] b[6:5] q[4] req[3:0]
  localparam int NSTEP = 29;
  localparam logic [16:0] STEPS [0:NSTEP-1] = '{
    {2'b01,1'b0,1'b0,4'hF,2'd3,2'd3,1'b0,4'd10}, // R10 clear
    {2'b01,1'b1,1'b0,4'hF,2'd3,2'd3,1'b0,4'd10}, // R10 edge under clear
    {2'b01,1'b0,1'b1,4'hF,2'd0,2'd0,1'b0,4'd5},  // R5 no edge
    {2'b01,1'b1,1'b1,4'hF,2'd0,2'd0,1'b1,4'd4},  // R4 capture d[0]
    {2'b01,1'b1,1'b1,4'h0,2'd0,2'd0,1'b1,4'd5},  // R5 data change high
    {2'b01,1'b0,1'b1,4'h0,2'd0,2'd0,1'b1,4'd5},  // R5 falling edge
    {2'b01,1'b1,1'b1,4'h0,2'd0,2'd0,1'b0,4'd4},  // R4 capture 0
    {2'b01,1'b0,1'b1,4'h4,2'd2,2'd0,1'b0,4'd5},  // R5
    {2'b01,1'b1,1'b1,4'h4,2'd2,2'd0,1'b1,4'd4},  // R4 capture d[2]
    {2'b01,1'b1,1'b0,4'h4,2'd2,2'd0,1'b0,4'd10}, // R10 clear while high
    {2'b10,1'b1,1'b0,4'h0,2'd0,2'd0,1'b0,4'd6},  // R6
    {2'b10,1'b1,1'b0,4'h1,2'd0,2'd0,1'b1,4'd8},  // R8 clear ignored
    {2'b10,1'b0,1'b0,4'h1,2'd0,2'd0,1'b1,4'd8},  // R8
    {2'b10,1'b0,1'b1,4'h0,2'd0,2'd0,1'b1,4'd7},  // R7 hold
    {2'b10,1'b1,1'b1,4'h0,2'd0,2'd0,1'b0,4'd6},  // R6
    {2'b10,1'b0,1'b1,4'h0,2'd0,2'd0,1'b0,4'd7},  // R7
    {2'b10,1'b0,1'b1,4'hF,2'd0,2'd0,1'b0,4'd7},  // R7
    {2'b11,1'b0,1'b0,4'hF,2'd0,2'd0,1'b0,4'd10}, // R10 latch clear
    {2'b11,1'b1,1'b0,4'hF,2'd0,2'd0,1'b0,4'd10}, // R10 gate high
    {2'b11,1'b1,1'b1,4'h2,2'd1,2'd1,1'b1,4'd9},  // R9 picks d[1]
    {2'b11,1'b1,1'b1,4'hD,2'd1,2'd1,1'b0,4'd9},  // R9
    {2'b11,1'b1,1'b1,4'hC,2'd3,2'd0,1'b0,4'd9},  // R9 high half ignored
    {2'b11,1'b1,1'b1,4'hD,2'd3,2'd0,1'b1,4'd9},  // R9 picks d[0]
    {2'b11,1'b0,1'b1,4'hD,2'd3,2'd0,1'b1,4'd7},  // R7
    {2'b11,1'b0,1'b1,4'h0,2'd3,2'd0,1'b1,4'd7},  // R7
    {2'b11,1'b0,1'b0,4'h0,2'd3,2'd0,1'b0,4'd10}, // R10 clear, gate low
    {2'b00,1'b0,1'b0,4'h8,2'd1,2'd1,1'b0,4'd3},  // R3
    {2'b00,1'b0,1'b0,4'h8,2'd3,2'd1,1'b1,4'd3},  // R3
    {2'b00,1'b1,1'b0,4'h8,2'd3,2'd1,1'b1,4'd3}   // R3 clock no effect
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic ref_y(input logic [3:0] dv, input logic [1:0] av,
                                 input logic [1:0] bv);
    logic s0, s1;
    s0 = av[0] & bv[0];
    s1 = av[1] | bv[1];
    return (!s1 & !s0 & dv[0]) | (!s1 & s0 & dv[1]) |
           (s1 & !s0 & dv[2]) | (s1 & s0 & dv[3]);
  endfunction

  initial begin
    #12;
    chk("R10 reset", q, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [16:0] s;
      s = STEPS[i];
      mode = s[16:15]; clr_n = s[13]; d = s[12:9]; a = s[8:7]; b = s[6:5];
      #1;
      cell_clk = s[14];
      #2;
      chk($sformatf("R%0d step %0d", s[3:0], i), q, s[4]);
    end

    // R1 R2: exhaustive select/data sweep in every mode
    clr_n = 1'b0;
    cell_clk = 1'b0;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        v = 8'(i);
        d = v[7:4]; a = v[3:2]; b = v[1:0];
        #1;
        chk($sformatf("R1/R2 mode %0d vec %0d", m, i), y, ref_y(d, a, b));
        if (m == 0) chk("R3 sweep", q, ref_y(d, a, b));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule